// File: doc/BRIEF.md
# Zero-Turnaround Late-Write SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous static RAM. Its bus can switch from read to write and back with no idle cycle between them. Every control input, the address and the write data are captured on the rising clock edge.

The write data trails its command by the same number of cycles as read data trails a read command. Because the two lags match, a bus master can issue read, write, read, write on consecutive cycles and keep the data bus busy on every cycle. A strap selects one of two latency modes:

- **Pipelined:** two cycles for both read data and write data.
- **Flow-through:** one cycle for both.

The array stores words of 2 or 4 bytes, with 9 bits per byte. A write can update any subset of the bytes. A built-in two-bit counter generates short bursts. Pending writes are tracked so that a read of an address not yet written to the array still returns the new data.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only while `ce1N` is 0, `ce2` is 1 and `ce3N` is 0 with `advLd` low. Any other combination with `advLd` low is a deselect: no array access, and the bus is not driven in that command's data cycle.
- R2: With `pipeSel` = 1, a read command taken at active edge n drives its word on `dqOut` with `dqOe` = 1 in the cycle just before active edge n+2.
- R3: A write command taken at active edge n stores `dqIn` sampled at active edge n+2 (`pipeSel` = 1) or n+1 (`pipeSel` = 0). Writes and reads may follow each other on every cycle with no idle cycle.
- R4: `byteWeN` is active low. Bit b controls bits [9b+8:9b] of the word. Bytes whose bit is 1 keep their old contents.
- R5: A write command with every `byteWeN` bit at 1 is an abort: the array is unchanged and the bus stays undriven.
- R6: While `ckeN` is 1, no command is taken, no write data is stored and the outputs hold. A pipelined read keeps driving and a pending write cycle stays undriven.
- R7: `outEnN` = 1 forces `dqOe` to 0 in the same cycle, with no clock edge needed.
- R8: `dqOe` is 0 during write data cycles and idle cycles.
- R9: A read whose address matches an earlier write that is not yet stored returns the new bytes of that write, merged with the array bytes that the write leaves alone.
- R10: With `advLd` = 1 the previous command type is repeated. The chip enables and `weN` are ignored. The address keeps its upper bits and adds 1 modulo 4 to bits [1:0]. A continue that follows a deselect stays deselected.
- R11: With `pipeSel` = 0, a read taken at active edge n drives its word in the cycle just before active edge n+1.
- R12: While `rst_n` is 0 and just after reset, `dqOe` is 0 and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipeSel | input | 1 | Mode strap: 1 pipelined, 0 flow-through |
| ckeN | input | 1 | Clock enable, active low; 1 stalls the block |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | 0 write, 1 read |
| advLd | input | 1 | 0 loads a new command, 1 continues the burst |
| byteWeN | input | BYTES | Per-byte write strobes, active low |
| addr | input | log2(DEPTH) | Word address |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dqIn | input | 9*BYTES | Write data from the bus |
| dqOut | output | 9*BYTES | Read data to the bus |
| dqOe | output | 1 | Bus driver enable |

## Verification
In pipelined mode, a write can be stored at the same edge at which a read of the same address fetches its word. The fetch then has to take some bytes from `dqIn` and the rest from the array.

The bench provokes this in two ways:
- a directed loop of write/read pairs to one address on adjacent cycles, with mixed byte strobes;
- a random mix that also inserts stalls between the two commands.

Each result is judged against a bench model. The model applies write data to its own copy of the array only at the edge on which that data is due. It compares every read word with that copy just before the edge on which the word is due.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int BYTE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;   // clock enabled this cycle
    logic memWr;  // store write data at this edge
    logic rdNow;  // command in stage one is a read
    logic pipe;   // pipelined mode
  } strobe_t;
endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipeSel,
  input  logic             ckeN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             weN,
  input  logic             advLd,
  input  logic [BYTES-1:0] byteWeN,
  input  logic [AW-1:0]    addr,
  output strobe_t          strb,
  output logic [AW-1:0]    rdAddr,
  output logic [AW-1:0]    wrAddr,
  output logic [BYTES-1:0] wrBe,
  output logic [BYTES-1:0] fwdBe
);
  logic             step, sel;
  op_e              op1, op2, opNext;
  logic [AW-1:0]    a1, a2, aNext;
  logic [BYTES-1:0] be1, be2, beNext;

  // Command decode: load or burst continue
  always_comb begin
    step = !ckeN;
    sel  = !ce1N && ce2 && !ce3N;
    if (!advLd) begin
      aNext = addr;
      if (!sel)     opNext = OP_IDLE;
      else if (weN) opNext = OP_READ;
      else          opNext = OP_WRITE;
    end else begin
      opNext      = op1;
      aNext       = a1;
      aNext[1:0]  = a1[1:0] + 2'd1;
    end
    beNext = (opNext == OP_WRITE) ? ~byteWeN : '0;
  end

  // Two command stages; stage two exists for the double late write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1 <= OP_IDLE;
      op2 <= OP_IDLE;
      a1  <= '0;
      a2  <= '0;
      be1 <= '0;
      be2 <= '0;
    end else if (step) begin
      op1 <= opNext;
      a1  <= aNext;
      be1 <= beNext;
      op2 <= op1;
      a2  <= a1;
      be2 <= be1;
    end
  end

  always_comb begin
    strb.step  = step;
    strb.pipe  = pipeSel;
    strb.rdNow = (op1 == OP_READ);
    rdAddr     = a1;
    if (pipeSel) begin
      strb.memWr = step && (op2 == OP_WRITE) && (|be2);
      wrAddr     = a2;
      wrBe       = be2;
      fwdBe      = (op2 == OP_WRITE && a2 == a1) ? be2 : '0;
    end else begin
      strb.memWr = step && (op1 == OP_WRITE) && (|be1);
      wrAddr     = a1;
      wrBe       = be1;
      fwdBe      = '0;
    end
  end

  // R6
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckeN |=> ($stable(op1) && $stable(a1) && $stable(op2) && $stable(a2)));

  // R1
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ckeN && !advLd && !(!ce1N && ce2 && !ce3N)) |=> (op1 == OP_IDLE));

  // R10
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ckeN && advLd) |=> ((a1[1:0] == $past(a1[1:0]) + 2'd1) && (op1 == $past(op1))));
endmodule

// File: rtl/zt_dp.sv
module zt_dp
  import zt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int BYTES = 4,
  parameter int DEPTH = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strb,
  input  logic [AW-1:0]           rdAddr,
  input  logic [AW-1:0]           wrAddr,
  input  logic [BYTES-1:0]        wrBe,
  input  logic [BYTES-1:0]        fwdBe,
  input  logic                    outEnN,
  input  logic [BYTES*BYTE_W-1:0] dqIn,
  output logic [BYTES*BYTE_W-1:0] dqOut,
  output logic                    dqOe
);
  localparam int W = BYTES * BYTE_W;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] arrWord, rdWord, qReg;
  logic         qVal;

  assign arrWord = mem[rdAddr];

  // Byte-wise merge of a write still in flight into the read word
  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign rdWord[b*BYTE_W +: BYTE_W] = fwdBe[b] ? dqIn[b*BYTE_W +: BYTE_W]
                                                 : arrWord[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.memWr) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wrBe[b]) mem[wrAddr][b*BYTE_W +: BYTE_W] <= dqIn[b*BYTE_W +: BYTE_W];
      end
    end
  end

  // Output register, used in pipelined mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qVal <= 1'b0;
      qReg <= '0;
    end else if (strb.step) begin
      qVal <= strb.rdNow;
      qReg <= rdWord;
    end
  end

  assign dqOut = strb.pipe ? qReg : rdWord;
  assign dqOe  = !outEnN && (strb.pipe ? qVal : strb.rdNow);

  // R7
  oe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !dqOe);

  // R6
  pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.pipe && !strb.step) |=> ($stable(dqOut) && $stable(qVal)));

  // R2
  pipe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.pipe && strb.step && strb.rdNow) |=> qVal);
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pipeSel,
  input  logic                       ckeN,
  input  logic                       ce1N,
  input  logic                       ce2,
  input  logic                       ce3N,
  input  logic                       weN,
  input  logic                       advLd,
  input  logic [BYTES-1:0]           byteWeN,
  input  logic [$clog2(DEPTH)-1:0]   addr,
  input  logic                       outEnN,
  input  logic [BYTES*BYTE_W-1:0]    dqIn,
  output logic [BYTES*BYTE_W-1:0]    dqOut,
  output logic                       dqOe
);
  localparam int AW = $clog2(DEPTH);

  strobe_t          strb;
  logic [AW-1:0]    rdAddr, wrAddr;
  logic [BYTES-1:0] wrBe, fwdBe;

  zt_ctrl #(.AW(AW), .BYTES(BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pipeSel(pipeSel), .ckeN(ckeN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .weN(weN), .advLd(advLd),
    .byteWeN(byteWeN), .addr(addr), .strb(strb), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .wrBe(wrBe), .fwdBe(fwdBe)
  );

  zt_dp #(.AW(AW), .BYTES(BYTES), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .wrBe(wrBe), .fwdBe(fwdBe), .outEnN(outEnN),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam int DEPTH = 16;
  localparam int BYTES = 4;
  localparam int AW    = 4;
  localparam int W     = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pipeSel = 1'b1, ckeN = 1'b1;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, weN = 1'b1, advLd = 1'b0, outEnN = 1'b1;
  logic [BYTES-1:0] byteWeN = '1;
  logic [AW-1:0]    addr = '0;
  logic [W-1:0]     dqIn = '0;
  logic [W-1:0]     dqOut;
  logic             dqOe;

  always #10 clk = ~clk;

  zt_sram #(.DEPTH(DEPTH), .BYTES(BYTES)) i_zt_sram (
    .clk(clk), .rst_n(rst_n), .pipeSel(pipeSel), .ckeN(ckeN), .ce1N(ce1N),
    .ce2(ce2), .ce3N(ce3N), .weN(weN), .advLd(advLd), .byteWeN(byteWeN),
    .addr(addr), .outEnN(outEnN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [W-1:0] model [DEPTH];

  // Bus slots indexed by active edge number modulo 8
  int               sKind [8];
  logic [AW-1:0]    sAddr [8];
  logic [BYTES-1:0] sBe   [8];
  logic [W-1:0]     sData [8];
  string            sTag  [8];

  int            edgeNo   = 0;
  int            lastKind = 0;
  logic [AW-1:0] lastAddr = '0;
  string         phaseTag = "";

  function automatic logic [W-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  task automatic check(input string tag, input logic expOe, input logic [W-1:0] expD);
    nChecks++;
    if (dqOe !== expOe) begin
      nFails++;
      $display("FAIL %s: dqOe actual=%0b expected=%0b", tag, dqOe, expOe);
    end else if (expOe && dqOut !== expD) begin
      nFails++;
      $display("FAIL %s: dqOut actual=%h expected=%h", tag, dqOut, expD);
    end
  endtask

  task automatic cyc(input logic cke_n, input logic e1n, input logic e2v, input logic e3n,
                     input logic wen, input logic adv, input logic [BYTES-1:0] ben,
                     input logic [AW-1:0] a, input logic oen);
    int k, sl, kind, lat;
    logic sel, burst, fwd;
    logic [AW-1:0] ra;
    string tg;
    @(negedge clk);
    ckeN = cke_n; ce1N = e1n; ce2 = e2v; ce3N = e3n; weN = wen;
    advLd = adv; byteWeN = ben; addr = a; outEnN = oen;
    k = (edgeNo + 1) % 8;
    dqIn = (sKind[k] == 2) ? sData[k] : rnd();
    #5;
    if (cke_n)    tg = "R6";
    else if (oen) tg = "R7";
    else          tg = sTag[k];
    check(tg, (sKind[k] == 1) && !oen, model[sAddr[k]]);
    @(posedge clk);
    if (!cke_n) begin
      if (sKind[k] == 2)
        for (int b = 0; b < BYTES; b++)
          if (sBe[k][b]) model[sAddr[k]][b*9 +: 9] = sData[k][b*9 +: 9];
      sKind[k] = 0;
      sTag[k]  = "R1";
      edgeNo++;
      sel = !e1n && e2v && !e3n;
      if (!adv) begin
        kind  = !sel ? 0 : (wen ? 1 : 2);
        ra    = a;
        burst = 1'b0;
      end else begin
        kind     = lastKind;
        ra       = lastAddr;
        ra[1:0]  = lastAddr[1:0] + 2'd1;
        burst    = 1'b1;
      end
      fwd = (kind == 1) && (lastKind == 2) && (lastAddr == ra);
      lastKind = kind;
      lastAddr = ra;
      lat = pipeSel ? 2 : 1;
      sl  = (edgeNo + lat) % 8;
      sKind[sl] = kind;
      sAddr[sl] = ra;
      sBe[sl]   = (kind == 2) ? ~ben : '0;
      sData[sl] = rnd();
      if (kind == 0)                          sTag[sl] = "R1";
      else if (kind == 2 && ben == {BYTES{1'b1}}) sTag[sl] = "R5";
      else if (kind == 2)                     sTag[sl] = "R8";
      else if (phaseTag != "")                sTag[sl] = phaseTag;
      else if (fwd)                           sTag[sl] = "R9";
      else if (burst)                         sTag[sl] = "R10";
      else if (pipeSel)                       sTag[sl] = "R2";
      else                                    sTag[sl] = "R11";
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '1, '0, 1'b0);
  endtask

  task automatic doReset(input logic pipe);
    @(negedge clk);
    rst_n = 1'b0; pipeSel = pipe; ckeN = 1'b1; outEnN = 1'b0; advLd = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    // R12: no drive while in reset even with output enable active
    check("R12", 1'b0, '0);
    for (int i = 0; i < 8; i++) begin sKind[i] = 0; sTag[i] = "R12"; end
    edgeNo = 0; lastKind = 0; lastAddr = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic runMode(input logic pipe);
    logic [AW-1:0] ra;
    int r;
    doReset(pipe);
    // R12: idle right after reset, burst continue stays idle
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, 1'b0);
    idle(2);
    // R3: full-word writes then back-to-back reads
    phaseTag = "R3";
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, AW'(i), 1'b0);
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, AW'(i), 1'b0);
    // R4 and R5: every strobe pattern, all-ones pattern is an abort
    phaseTag = "R4";
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, BYTES'(i), AW'(i), 1'b0);
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, AW'(i), 1'b0);
    phaseTag = "";
    // R9: write then read of the same address on adjacent cycles
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, BYTES'(i * 5), AW'(i), 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, AW'(i), 1'b0);
    end
    // R10: read bursts from every start offset
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, AW'(i + 4), 1'b0);
      for (int j = 0; j < 4; j++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, '0, 1'b0);
    end
    // Random mix with stalls, deselects, bursts and output enable
    for (int n = 0; n < 1500; n++) begin
      logic cn, e1, e2v, e3, w, ad, oe;
      logic [BYTES-1:0] ben;
      cn = ($urandom() % 6) == 0;
      r  = $urandom() % 24;
      e1 = (r == 0); e2v = (r != 1); e3 = (r == 2);
      w  = $urandom() % 2 == 0;
      ad = ($urandom() % 4) == 0;
      ben = (($urandom() % 6) == 0) ? '1 : BYTES'($urandom());
      ra = AW'($urandom());
      oe = ($urandom() % 8) == 0;
      cyc(cn, e1, e2v, e3, w, ad, ben, ra, oe);
    end
    idle(3);
    // Final readback of the whole array
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, AW'(i), 1'b0);
    idle(3);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin sKind[i] = 0; sTag[i] = "R12"; sAddr[i] = '0; end
    runMode(1'b1);   // pipelined
    runMode(1'b0);   // flow-through
    runMode(1'b1);
    summary();
  end

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R12: watchdog actual=running expected=finished");
    summary();
  end
endmodule